// File: doc/BRIEF.md
# Bus-Loaded Selection Unit

This unit performs a select-one-of-N operation over a shared data bus in sequential steps. It does not receive its candidates as parallel inputs. Each candidate arrives as a bus word plus an attribute tag. A load strobe stores the pair in the next free slot. A select strobe then latches the slot index from the low bits of the bus. Later, a drive strobe places the chosen word and its tag on the output.

A sequencer controls the unit through three single-bit strobes. It raises at most one of them per cycle. When the drive strobe is low, the outputs are zero, so the unit can be OR-combined with other units onto a common result bus. The result may be driven on several cycles, once for each consumer. After it has been driven at least once, the next load strobe begins a fresh operation. That load discards every previously captured slot.

Top module: `bus_mux_unit`

## Requirements
- R1: Synchronous active-high reset clears every slot, the slot pointer and the select register. After reset, driving the output with any select value yields zero data and zero attribute.
- R2: The strobes `load_stb`, `pick_stb` and `drive_stb` are mutually exclusive. Idle cycles between a select and a drive do not disturb the captured result.
- R3: Load strobes fill slots 0, 1, 2, … in order of arrival. A select value n picks the word stored by the (n+1)-th load of the current operation.
- R4: The data word and its attribute are stored together and presented together on `res_data` and `res_attr`.
- R5: While `drive_stb` is low, `res_data` and `res_attr` are all zeros.
- R6: The select value is the low `SEL_W` bits of `bus_data`, captured on `pick_stb`. A drive issued two cycles after the select strobe, or later, shows the selected word.
- R7: Repeated drive cycles with no intervening strobe present the same result each time.
- R8: The first load strobe after a drive cycle starts a new operation. It writes slot 0, and all slots from the previous operation then read as empty.
- R9: Selecting a slot that the current operation has not written yields zero data and zero attribute.
- R10: Once all 2^SEL_W slots hold words, further load strobes in the same operation are ignored. They neither overwrite nor wrap into earlier slots.
- R11: The select register keeps its value until the next `pick_stb`. A new select issued after a drive, with no load in between, reads the same stored slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Capture bus word and attribute into the next slot |
| pick_stb | input | 1 | Capture low SEL_W bits of bus_data as the slot index |
| drive_stb | input | 1 | Present the selected word on the result outputs |
| bus_data | input | DATA_W | Shared bus data |
| bus_attr | input | ATTR_W | Attribute tag accompanying bus_data |
| res_data | output | DATA_W | Result data, zero unless driving |
| res_attr | output | ATTR_W | Result attribute, zero unless driving |

## Verification
The bench uses the default widths: 16-bit data, 4-bit attribute and a 4-bit select, which gives 16 slots. With 16 slots, a full operation takes 16 loads and a seventeenth load exercises the ignore-when-full rule within a short run. Every test word gets a nonzero attribute that differs from its neighbours', so a data/attribute mismatch or an off-by-one slot shows up as a visible difference. Each read is driven at the earliest legal cycle, two cycles after the select strobe, which exposes any missing or extra pipeline stage.

// File: rtl/mux_unit_pkg.sv
package mux_unit_pkg;

    // Decoded form of the three control strobes.
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_LOAD   = 2'd1,
        CMD_SELECT = 2'd2,
        CMD_DRIVE  = 2'd3
    } cmd_e;

    // Strobes are exclusive by contract; a fixed order keeps decoding total.
    function automatic cmd_e decode_strobes(input logic ld, input logic pk, input logic dv);
        if (ld)      return CMD_LOAD;
        else if (pk) return CMD_SELECT;
        else if (dv) return CMD_DRIVE;
        else         return CMD_IDLE;
    endfunction

    function automatic int unsigned slot_count(input int unsigned sel_w);
        return 32'd1 << sel_w;
    endfunction

endpackage

// File: rtl/mux_slot_bank.sv
module mux_slot_bank
    import mux_unit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ATTR_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  cmd_e                      cmd,
    input  logic [DATA_W+ATTR_W-1:0]  wr_word,
    input  logic [SEL_W-1:0]          rd_idx,
    output logic [DATA_W+ATTR_W-1:0]  rd_word,
    output logic                      rd_valid
);
    localparam int NSLOT  = int'(slot_count(SEL_W));
    localparam int WORD_W = DATA_W + ATTR_W;
    localparam int PTR_W  = SEL_W + 1;

    logic [PTR_W-1:0]       wr_ptr;
    logic                   served;
    logic [NSLOT-1:0]       valid;
    logic [NSLOT*WORD_W-1:0] slot_flat;

    logic             is_load;
    logic             restart;
    logic             full;
    logic             accept;
    logic [SEL_W-1:0] tgt;

    always_comb begin
        is_load = (cmd == CMD_LOAD);
        restart = is_load && served;
        full    = (wr_ptr == PTR_W'(NSLOT));
        accept  = is_load && (restart || !full);
        tgt     = restart ? '0 : wr_ptr[SEL_W-1:0];
    end

    // Operation control: pointer and "result already driven" flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            served <= 1'b0;
        end else begin
            if (cmd == CMD_DRIVE)
                served <= 1'b1;
            else if (is_load)
                served <= 1'b0;
            if (accept)
                wr_ptr <= restart ? PTR_W'(1) : wr_ptr + PTR_W'(1);
        end
    end

    // One storage slot per select code.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [WORD_W-1:0] q;
        logic              v;
        logic              hit;
        assign hit = accept && (tgt == SEL_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                v <= 1'b0;
            end else if (hit) begin
                q <= wr_word;
                v <= 1'b1;
            end else if (restart) begin
                v <= 1'b0;
            end
        end
        assign slot_flat[g*WORD_W +: WORD_W] = q;
        assign valid[g] = v;
    end

    always_comb begin
        rd_word  = slot_flat[rd_idx*WORD_W +: WORD_W];
        rd_valid = valid[rd_idx];
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) rst |=> (wr_ptr == '0 && valid == '0)); // R1
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (is_load && !served && !full) |=> (wr_ptr == $past(wr_ptr) + PTR_W'(1))); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_load && !served && full) |=> (wr_ptr == $past(wr_ptr) && $stable(valid))); // R10
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (is_load && served) |=> (wr_ptr == PTR_W'(1) && valid == NSLOT'(1))); // R8

endmodule

// File: rtl/mux_sel_reg.sv
module mux_sel_reg
    import mux_unit_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [SEL_W-1:0] bus_sel,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (cmd == CMD_SELECT)
            sel_q <= bus_sel;
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SELECT) |=> (sel_q == $past(bus_sel))); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_SELECT) |=> $stable(sel_q)); // R11

endmodule

// File: rtl/mux_out_stage.sv
module mux_out_stage #(
    parameter int DATA_W = 16,
    parameter int ATTR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DATA_W+ATTR_W-1:0] rd_word,
    input  logic                     rd_valid,
    input  logic                     drive,
    output logic [DATA_W-1:0]        res_data,
    output logic [ATTR_W-1:0]        res_attr
);
    localparam int WORD_W = DATA_W + ATTR_W;

    // Registered pick: the second stage of the two-cycle read rule.
    logic [WORD_W-1:0] pick_q;

    always_ff @(posedge clk) begin
        if (rst)
            pick_q <= '0;
        else
            pick_q <= rd_valid ? rd_word : '0;
    end

    always_comb begin
        res_data = drive ? pick_q[DATA_W-1:0]      : '0;
        res_attr = drive ? pick_q[WORD_W-1:DATA_W] : '0;
    end

    AST_PICK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (pick_q == '0)); // R9

endmodule

// File: rtl/bus_mux_unit.sv
module bus_mux_unit
    import mux_unit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ATTR_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic              pick_stb,
    input  logic              drive_stb,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ATTR_W-1:0] bus_attr,
    output logic [DATA_W-1:0] res_data,
    output logic [ATTR_W-1:0] res_attr
);
    localparam int WORD_W = DATA_W + ATTR_W;

    cmd_e              cmd;
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] rd_word;
    logic              rd_valid;
    logic [WORD_W-1:0] wr_word;

    always_comb begin
        cmd     = decode_strobes(load_stb, pick_stb, drive_stb);
        wr_word = {bus_attr, bus_data};
    end

    mux_slot_bank #(.DATA_W(DATA_W), .ATTR_W(ATTR_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wr_word  (wr_word),
        .rd_idx   (sel_q),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    mux_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .bus_sel (bus_data[SEL_W-1:0]),
        .sel_q   (sel_q)
    );

    mux_out_stage #(.DATA_W(DATA_W), .ATTR_W(ATTR_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .drive    (drive_stb),
        .res_data (res_data),
        .res_attr (res_attr)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_stb, pick_stb, drive_stb})); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !drive_stb |-> (res_data == '0 && res_attr == '0)); // R5
    AST_REPEAT_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (drive_stb && $past(drive_stb)) |-> ($stable(res_data) && $stable(res_attr))); // R7

endmodule

// File: tb/bus_mux_unit_tb.sv
module bus_mux_unit_tb;
    localparam int DATA_W = 16;
    localparam int ATTR_W = 4;
    localparam int SEL_W  = 4;
    localparam int NVEC   = 8;

    // Vector: {load count [8:4], select [3:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {5'd4,  4'd2}, {5'd1,  4'd0}, {5'd16, 4'd15}, {5'd7, 4'd6},
        {5'd3,  4'd9}, {5'd12, 4'd11}, {5'd2, 4'd1},  {5'd5, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_stb = 1'b0, pick_stb = 1'b0, drive_stb = 1'b0;
    logic [DATA_W-1:0] bus_data = '0;
    logic [ATTR_W-1:0] bus_attr = '0;
    logic [DATA_W-1:0] res_data;
    logic [ATTR_W-1:0] res_attr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_mux_unit #(.DATA_W(DATA_W), .ATTR_W(ATTR_W), .SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst(rst), .load_stb(load_stb), .pick_stb(pick_stb),
        .drive_stb(drive_stb), .bus_data(bus_data), .bus_attr(bus_attr),
        .res_data(res_data), .res_attr(res_attr)
    );

    function automatic logic [DATA_W-1:0] wdata(input int op, input int k);
        return DATA_W'(op * 256 + k + 1);
    endfunction

    function automatic logic [ATTR_W-1:0] wattr(input int op, input int k);
        return ATTR_W'(((op + k) % 15) + 1);
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] ed, input logic [ATTR_W-1:0] ea);
        checks++;
        if (res_data !== ed || res_attr !== ea) begin
            errors++;
            $display("FAIL %s: got data=%h attr=%h expected data=%h attr=%h",
                     req, res_data, res_attr, ed, ea);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_load(input logic [DATA_W-1:0] d, input logic [ATTR_W-1:0] a);
        @(negedge clk); load_stb = 1'b1; bus_data = d; bus_attr = a;
        @(negedge clk); load_stb = 1'b0; bus_data = '0; bus_attr = '0;
    endtask

    task automatic do_pick(input int s);
        @(negedge clk); pick_stb = 1'b1; bus_data = DATA_W'(s);
        @(negedge clk); pick_stb = 1'b0; bus_data = '0;
    endtask

    // Drive at the earliest legal cycle (two cycles after the select strobe).
    task automatic do_read(input string req, input logic [DATA_W-1:0] ed, input logic [ATTR_W-1:0] ea);
        @(negedge clk); drive_stb = 1'b1;
        #1 chk(req, ed, ea);
        @(negedge clk); drive_stb = 1'b0;
    endtask

    task automatic load_op(input int op, input int n);
        for (int k = 0; k < n; k++) do_load(wdata(op, k), wattr(op, k));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: nothing stored after reset
        do_pick(5);
        do_read("R1 reset slot", '0, '0);
        do_pick(0);
        do_read("R1 reset slot0", '0, '0);

        // Vector table: R3/R4/R6/R7/R9, each entry its own operation
        for (int v = 0; v < NVEC; v++) begin
            int n;
            int s;
            logic [DATA_W-1:0] ed;
            logic [ATTR_W-1:0] ea;
            n = int'(VEC[v][8:4]);
            s = int'(VEC[v][3:0]);
            load_op(v + 1, n);
            // R5: idle output is zero while loading has just occurred
            #1 chk("R5 idle zero", '0, '0);
            do_pick(s);
            ed = (s < n) ? wdata(v + 1, s) : '0;
            ea = (s < n) ? wattr(v + 1, s) : '0;
            do_read((s < n) ? "R3 R4 R6 pick" : "R9 unwritten", ed, ea);
            do_read("R7 second read", ed, ea);
        end

        // R8: new operation discards old slots
        load_op(20, 3);
        do_pick(0);
        do_read("R8 setup", wdata(20, 0), wattr(20, 0));
        do_load(wdata(21, 0), wattr(21, 0));
        do_pick(2);
        do_read("R8 old slot gone", '0, '0);
        do_pick(0);
        do_read("R8 new slot0", wdata(21, 0), wattr(21, 0));

        // R11: reselect after a drive with no load keeps stored slots
        load_op(22, 4);
        do_pick(1);
        do_read("R11 first", wdata(22, 1), wattr(22, 1));
        do_pick(3);
        do_read("R11 reselect", wdata(22, 3), wattr(22, 3));

        // R10: seventeenth load ignored
        load_op(23, 17);
        do_pick(15);
        do_read("R10 last slot", wdata(23, 15), wattr(23, 15));
        do_pick(0);
        do_read("R10 no wrap", wdata(23, 0), wattr(23, 0));

        // R2: idle cycles between select and drive
        load_op(24, 2);
        do_pick(1);
        repeat (6) @(negedge clk);
        do_read("R2 idle gap", wdata(24, 1), wattr(24, 1));

        // R1: reset in the middle of an operation
        load_op(25, 3);
        do_reset();
        do_pick(1);
        do_read("R1 mid reset", '0, '0);
        #1 chk("R5 after drive", '0, '0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule